// File: doc/BRIEF.md
# Serial Burst Access Port for an Eight-Register Bank

This block lets an SPI master reach a small bank of byte-wide registers. It works as a slave. Each transaction is a burst framed by an active-low chip select. The first byte of a burst is a command. That byte sets the transfer direction and the register where access begins. Every byte that follows reads or writes the next register in turn, and the pointer wraps around the top of the bank.

The serial pins are sampled in the system clock domain and edge-detected there, so the system clock must run several times faster than SCLK. Writes reach the register bank as a one-clock strobe with a decoded register select and a shared data byte. The whole bank feeds read data in parallel.

Reads are pipelined. The byte returned while the command is shifted in comes from the register the pointer held before that command. This lets a master collect the next value of a running scan without spending an extra byte.

Top module: `spi_burst_regs`

## Requirements
- R1: After reset, MISO is 0 and no write strobe is active. The byte returned during the first command transfer after reset is 0x00.
- R2: The first complete byte after chip select falls is the command. Bit 7 = 1 selects a write burst and bit 7 = 0 selects a read burst. Bits 2:0 give the starting register. Bits 6:3 have no effect.
- R3: The byte shifted out, MSB first, during a command transfer is the register at the pointer left by the previous burst.
- R4: In a write burst, each complete data byte gives exactly one clock of strobe on reg_wr_en[ptr] and on no other bit, with reg_wr_data equal to the byte received MSB first.
- R5: In a read burst, data byte k returns register (start + k) mod 8. Each byte is ready on MISO before the first SCLK edge of that byte.
- R6: The pointer increments after every data byte, wraps from 7 to 0, and keeps its value between bursts.
- R7: If chip select rises in the middle of a byte, no write and no pointer increment happen for that byte, and the next burst starts with a command byte.
- R8: The SPI mode is CPOL=0, CPHA=0: MOSI is sampled on SCLK rising edges and MISO changes after falling edges. MISO is 0 while chip select is high.

Register i is read from reg_rd_data[8*i +: 8] and written through reg_wr_en[i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low chip select framing a burst |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| reg_wr_en | output | NUM_REGS | One-clock write strobe, one bit per register |
| reg_wr_data | output | DATA_W | Byte to be written |
| reg_rd_data | input | NUM_REGS*DATA_W | Current contents of all registers |

## Verification
The bench runs five bursts. Each burst starts from the pointer that the previous one left behind, so the pipelined command return tells a pointer that persists apart from one that resets at chip select. A write burst with command bits 6:3 set crosses from register 7 to 0. A following read burst crosses the same boundary, which tells correct wrap-around apart from saturation and shows that writes landed at the decoded address. A burst cut off after four bits of a data byte, followed by a read, separates discarding the partial byte from committing it or advancing the pointer.

// File: rtl/spi_burst_regs.sv
module spi_burst_regs #(
  parameter int NUM_REGS    = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_sclk,
  input  logic                       spi_cs_n,
  input  logic                       spi_mosi,
  output logic                       spi_miso,
  output logic [NUM_REGS-1:0]        reg_wr_en,
  output logic [DATA_W-1:0]          reg_wr_data,
  input  logic [NUM_REGS*DATA_W-1:0] reg_rd_data
);
  localparam int ADDR_W = $clog2(NUM_REGS);
  localparam int BIT_W  = $clog2(DATA_W);

  logic [SYNC_STAGES-1:0] cs_sy, sk_sy, mo_sy;
  logic cs_q, sk_q;
  logic in_burst, cmd_ph, wr_mode, armed, load_pend;
  logic [ADDR_W-1:0] ptr;
  logic [BIT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_sr, tx_sr;

  wire cs_s    = cs_sy[SYNC_STAGES-1];
  wire sk_s    = sk_sy[SYNC_STAGES-1];
  wire mo_s    = mo_sy[SYNC_STAGES-1];
  wire cs_fall = cs_q & ~cs_s;
  wire cs_rise = ~cs_q & cs_s;
  wire sk_rise = ~sk_q & sk_s;
  wire sk_fall = sk_q & ~sk_s;
  wire [DATA_W-1:0] rx_nxt = {rx_sr[DATA_W-2:0], mo_s};
  wire [DATA_W-1:0] rd_sel = reg_rd_data[ptr*DATA_W +: DATA_W];
  wire byte_end = (bit_cnt == BIT_W'(DATA_W-1));

  assign spi_miso = in_burst & tx_sr[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= '1;
      sk_sy <= '0;
      mo_sy <= '0;
      cs_q  <= 1'b1;
      sk_q  <= 1'b0;
    end else begin
      cs_sy <= {cs_sy[SYNC_STAGES-2:0], spi_cs_n};
      sk_sy <= {sk_sy[SYNC_STAGES-2:0], spi_sclk};
      mo_sy <= {mo_sy[SYNC_STAGES-2:0], spi_mosi};
      cs_q  <= cs_s;
      sk_q  <= sk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_burst    <= 1'b0;
      cmd_ph      <= 1'b0;
      wr_mode     <= 1'b0;
      armed       <= 1'b0;
      load_pend   <= 1'b0;
      ptr         <= '0;
      bit_cnt     <= '0;
      rx_sr       <= '0;
      tx_sr       <= '0;
      reg_wr_en   <= '0;
      reg_wr_data <= '0;
    end else begin
      reg_wr_en <= '0;
      if (cs_fall) begin
        in_burst  <= 1'b1;
        cmd_ph    <= 1'b1;
        bit_cnt   <= '0;
        load_pend <= 1'b0;
        tx_sr     <= armed ? rd_sel : '0;
      end else if (cs_rise) begin
        in_burst <= 1'b0;
        bit_cnt  <= '0;
      end else if (in_burst) begin
        if (sk_rise) begin
          rx_sr   <= rx_nxt;
          bit_cnt <= bit_cnt + BIT_W'(1);
          if (byte_end) begin
            load_pend <= 1'b1;
            if (cmd_ph) begin
              cmd_ph  <= 1'b0;
              wr_mode <= rx_nxt[DATA_W-1];
              ptr     <= rx_nxt[ADDR_W-1:0];
              armed   <= 1'b1;
            end else begin
              if (wr_mode) begin
                reg_wr_en   <= NUM_REGS'(1) << ptr;
                reg_wr_data <= rx_nxt;
              end
              ptr <= ptr + ADDR_W'(1);
            end
          end
        end
        if (sk_fall) begin
          load_pend <= 1'b0;
          tx_sr     <= load_pend ? rd_sel : {tx_sr[DATA_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_burst_regs_chk.sv
module spi_burst_regs_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                spi_cs_n,
  input logic                spi_miso,
  input logic [NUM_REGS-1:0] reg_wr_en
);
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_wr_en)); // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en != '0) |=> (reg_wr_en == '0)); // R4
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
     && $past(spi_cs_n, 4)) |-> !spi_miso); // R8
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
     && $past(spi_cs_n, 4)) |-> (reg_wr_en == '0)); // R7
endmodule

bind spi_burst_regs spi_burst_regs_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n),
  .spi_miso(spi_miso), .reg_wr_en(reg_wr_en));

// File: tb/spi_burst_regs_tb_top.sv
module spi_burst_regs_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [7:0]  wr_en;
  logic [7:0]  wr_data;
  logic [63:0] rd_data;
  logic [7:0]  model [8];
  logic [10:0] exp_q [$];
  int checks = 0, errors = 0, wr_seen = 0;

  always #2 clk = ~clk;

  spi_burst_regs dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .reg_wr_en(wr_en), .reg_wr_data(wr_data), .reg_rd_data(rd_data));

  always_comb for (int i = 0; i < 8; i++) rd_data[8*i +: 8] = model[i];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      wait_clk(8);
      rx[i] = miso;
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    wait_clk(8);
  endtask

  task automatic cs_high();
    wait_clk(8);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic put_write(input logic [2:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  // scoreboard monitor: the bench's register bank
  always @(negedge clk) begin
    if (rst_n && wr_en != '0) begin
      logic [10:0] e;
      wr_seen++;
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected strobe", wr_en, 0);
      else begin
        e = exp_q.pop_front();
        chk(wr_en == (8'd1 << e[10:8]), "R4 strobe select", wr_en, 8'd1 << e[10:8]);
        chk(wr_data == e[7:0], "R4 write data", wr_data, e[7:0]);
      end
      for (int i = 0; i < 8; i++) if (wr_en[i]) model[i] = wr_data;
    end
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < 8; i++) model[i] = 8'(8'h11 * (i + 1));
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);
    chk(miso == 1'b0, "R1 miso at reset", miso, 0);
    chk(wr_en == '0, "R1 strobe at reset", wr_en, 0);

    // read burst from 3
    cs_low();
    spi_bits(8'h03, 8, rx); chk(rx == 8'h00, "R1 first command return", rx, 0);
    spi_bits(8'h00, 8, rx); chk(rx == 8'h44, "R5 read reg3", rx, 8'h44);
    spi_bits(8'h00, 8, rx); chk(rx == 8'h55, "R5 read reg4", rx, 8'h55);
    cs_high();
    chk(miso == 1'b0, "R8 miso idle", miso, 0);

    // write burst from 5 with bits 6:3 set, wraps 7->0
    cs_low();
    spi_bits(8'hFD, 8, rx); chk(rx == 8'h66, "R3 command return reg5", rx, 8'h66);
    put_write(3'd5, 8'hA1); spi_bits(8'hA1, 8, rx);
    put_write(3'd6, 8'hB2); spi_bits(8'hB2, 8, rx);
    put_write(3'd7, 8'hC3); spi_bits(8'hC3, 8, rx);
    put_write(3'd0, 8'hD4); spi_bits(8'hD4, 8, rx);
    cs_high();
    chk(wr_seen == 4, "R2 write burst count", wr_seen, 4);
    chk(exp_q.size() == 0, "R6 writes drained", exp_q.size(), 0);

    // read burst from 6, pointer left at 1
    cs_low();
    spi_bits(8'h06, 8, rx); chk(rx == 8'h22, "R3 command return reg1", rx, 8'h22);
    spi_bits(8'hFF, 8, rx); chk(rx == 8'hB2, "R5 read reg6", rx, 8'hB2);
    spi_bits(8'hFF, 8, rx); chk(rx == 8'hC3, "R6 read reg7", rx, 8'hC3);
    spi_bits(8'hFF, 8, rx); chk(rx == 8'hD4, "R6 wrap read reg0", rx, 8'hD4);
    cs_high();
    chk(wr_seen == 4, "R2 read burst writes nothing", wr_seen, 4);

    // write to 2, then truncated byte
    cs_low();
    spi_bits(8'h82, 8, rx); chk(rx == 8'h22, "R6 pointer kept", rx, 8'h22);
    put_write(3'd2, 8'h5A); spi_bits(8'h5A, 8, rx);
    spi_bits(8'hE7, 4, rx);
    cs_high();
    chk(wr_seen == 5, "R7 partial byte not written", wr_seen, 5);

    // read from 2: command return shows pointer 3
    cs_low();
    spi_bits(8'h02, 8, rx); chk(rx == 8'h44, "R7 pointer not advanced", rx, 8'h44);
    spi_bits(8'h00, 8, rx); chk(rx == 8'h5A, "R4 written value", rx, 8'h5A);
    spi_bits(8'h00, 8, rx); chk(rx == 8'h44, "R8 reg3 unchanged", rx, 8'h44);
    cs_high();
    chk(wr_seen == 5, "R7 no stray writes", wr_seen, 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule